// File: doc/BRIEF.md
# Programmable Sample Delay Line with Phase-Shifted Read Clock

This block delays a stream of sampled data words by a programmable whole number of sampling periods. Each sample is written into a dual-port RAM at an address from a free-running counter on the sampling clock. The read port runs on a second clock, which is a finely phase-shifted copy of the sampling clock. It reads the word that lies a programmed number of addresses behind the writer. Two instances are typically used in a feedback path: one evens out the delay between two sensing paths, the other trims the total loop delay.

The read address comes from the write counter and is retimed before the read port uses it. It is retimed either on the rising edge of the sampling clock or, through a half-cycle register, on its falling edge. The choice follows the programmed fine delay. A small delay, below the clock-to-output plus hold margin, keeps the rising edge. A larger delay that is still inside one period selects the falling edge. The depth and the edge choice are captured together on the sampling clock and carried into the read-clock domain as one word. A coarse step and the matching fine-delay jump therefore land on the same read edge, and the output stream sees no intermediate value.

Top module: `sample_delay_line`

## Requirements
- R1: On every rising sampling-clock edge with reset released, `din` is written at the write counter's address. The counter starts at 0 after reset, advances by one per edge and wraps after 256 words.
- R2: In rising-edge retime mode, the value loaded into `dout` at a read-clock rising edge equals `din` as sampled at sampling edge k−D. Here k is the last sampling edge at or before that read edge, and D is the applied depth.
- R3: The edge choice is compared on every sampling edge and registered. If `fine_dly` < `hold_margin` and `fine_dly` < `period`, rising-edge retime (code 0) is selected. If `hold_margin` ≤ `fine_dly` < `period`, falling-edge retime (code 1) is selected.
- R4: In falling-edge retime mode, the read address comes from a register loaded on the falling sampling edge with the rising-edge retimed address. A read edge in the first half of the period therefore returns the sample from edge k−1−D. A read edge in the second half returns the sample from edge k−D.
- R5: While `fine_dly` ≥ `period`, the edge choice keeps its previous value. After reset it is rising-edge retime.
- R6: A requested depth below 2 is applied as 2. Any depth from 2 up to 255 is applied as given.
- R7: Depth and edge choice are registered together on sampling edge m, then pass through two read-clock stages. A value present at sampling edge m first governs the read at read edge m+2. While they are unchanged, the read address advances by exactly one per read edge.
- R8: Reset is synchronous and active-low in both domains. While it is held, `dout` is 0. Applied depth defaults to 2 and the edge choice to rising.
- R9: A one-step depth change moves the output by exactly one sample at a single read edge: one sample is skipped when the depth shrinks and one is repeated when it grows. No other sample is lost or doubled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_smp | input | 1 | Sampling clock; write side, counter and address retiming |
| clk_rd | input | 1 | Phase-shifted copy of clk_smp; read port and configuration stages |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clocks |
| din | input | DATA_W | Sample to be delayed |
| depth | input | 8 | Requested coarse delay in sampling periods (2..255) |
| fine_dly | input | TICK_W | Programmed fine delay in ticks |
| hold_margin | input | TICK_W | Clock-to-output plus hold time in ticks |
| period | input | TICK_W | Sampling clock period in ticks |
| dout | output | DATA_W | Delayed sample, registered on clk_rd |

## Verification
A sample written at sampling edge j appears on `dout` at the read edge that follows sampling edge j+D. With falling-edge retime and an early read edge, it appears one edge later. A new depth or fine-delay value present at sampling edge m first takes effect at read edge m+2. The bench stores every input present at each sampling edge, indexed by that edge's count. Two nanoseconds after each read edge, it rebuilds the expected word from the entry two edges back and compares it with `dout`. Reads whose source would come before the first written sample are left out.

// File: rtl/sdl_pkg.sv
// Shared types for the sample delay line.
// Assumes an 8-bit RAM address; the depth range is tied to it.
package sdl_pkg;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned RAM_WORDS = 1 << ADDR_W;
    localparam int unsigned MIN_DEPTH = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } rt_edge_e;

    typedef struct packed {
        rt_edge_e               edge_sel;
        logic [ADDR_W-1:0]      depth;
    } dly_cfg_t;
endpackage

// File: rtl/sdl_cfg_capture.sv
// Captures the coarse depth and the retime edge choice on the sampling clock.
// The fine delay, margin and period are unsigned tick counts. A fine delay at
// or above the period is treated as invalid, and the previous edge is kept.
module sdl_cfg_capture
    import sdl_pkg::*;
#(
    parameter int unsigned TICK_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   depth_in,
    input  logic [TICK_W-1:0]   fine,
    input  logic [TICK_W-1:0]   margin,
    input  logic [TICK_W-1:0]   period,
    output dly_cfg_t            cfg_q
);
    localparam logic [ADDR_W-1:0] DEPTH_FLOOR = ADDR_W'(MIN_DEPTH);

    logic [ADDR_W-1:0] depth_lim;
    logic              fine_valid;
    logic              want_fall;

    // Clamp the depth and compare the fine delay against margin and period.
    always_comb begin
        depth_lim  = (depth_in < DEPTH_FLOOR) ? DEPTH_FLOOR : depth_in;
        fine_valid = (fine < period);
        want_fall  = (fine >= margin);
    end

    // Register depth and edge choice as one word on the sampling clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.depth    <= DEPTH_FLOOR;
            cfg_q.edge_sel <= EDGE_RISE;
        end else begin
            cfg_q.depth <= depth_lim;
            if (fine_valid)
                cfg_q.edge_sel <= want_fall ? EDGE_FALL : EDGE_RISE;
        end
    end

    // R3
    rise_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fine < margin && fine < period) |=> cfg_q.edge_sel == EDGE_RISE);

    // R3
    fall_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fine >= margin && fine < period) |=> cfg_q.edge_sel == EDGE_FALL);

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fine >= period) |=> $stable(cfg_q.edge_sel));
endmodule

// File: rtl/sdl_cfg_sync.sv
// Carries the configuration word into the read-clock domain through STAGES
// registers. Depth and edge travel as one word, so both change on one edge.
// Assumes the source word is held steady for longer than STAGES read cycles.
module sdl_cfg_sync
    import sdl_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  dly_cfg_t cfg_in,
    output dly_cfg_t cfg_out
);
    localparam dly_cfg_t RST_CFG = '{edge_sel: EDGE_RISE, depth: ADDR_W'(MIN_DEPTH)};

    dly_cfg_t stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Shift the configuration word one stage per read-clock edge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg[i] <= RST_CFG;
            else if (i == 0)
                stg[i] <= cfg_in;
            else
                stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
    end

    assign cfg_out = stg[STAGES-1];

    // R6
    applied_depth_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_out.depth >= ADDR_W'(MIN_DEPTH));
endmodule

// File: rtl/sdl_addr_retime.sv
// Retimes the write counter on the rising sampling edge, then copies it on
// the falling edge. One of the two copies is chosen, and the depth is
// subtracted to form the read address. Assumes the read clock edge lies
// within one period after the sampling edge.
module sdl_addr_retime
    import sdl_pkg::*;
(
    input  logic              clk_smp,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  rt_edge_e          edge_sel,
    input  logic [ADDR_W-1:0] depth,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ADDR_W-1:0] pos_q;
    logic [ADDR_W-1:0] neg_q;

    // Rising-edge copy of the write counter.
    always_ff @(posedge clk_smp) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= wr_ptr;
    end

    // Falling-edge copy of the rising-edge copy (inverted-clock retime).
    always_ff @(negedge clk_smp) begin
        if (!rst_n) neg_q <= '0;
        else        neg_q <= pos_q;
    end

    // Pick the retimed copy and step back by the coarse depth (mod RAM size).
    always_comb begin
        rd_addr = ((edge_sel == EDGE_FALL) ? neg_q : pos_q) - depth;
    end
endmodule

// File: rtl/sdl_dpram.sv
// Simple dual-port RAM: synchronous write on one clock and a registered read
// on the other. The read register resets to zero; the array does not reset.
module sdl_dpram
    import sdl_pkg::*;
#(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk_wr,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clk_rd,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [RAM_WORDS];

    // Write port on the sampling clock.
    always_ff @(posedge clk_wr) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port on the delayed clock.
    always_ff @(posedge clk_rd) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sample_delay_line.sv
// Programmable whole-period delay of a sample stream. The write side runs on
// clk_smp. The read side runs on clk_rd, a phase-shifted copy of clk_smp that
// lags it by less than one period. The depth and the retime edge are applied
// together in the read domain two read edges after they are captured.
module sample_delay_line
    import sdl_pkg::*;
#(
    parameter int unsigned DATA_W     = 14,
    parameter int unsigned TICK_W     = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk_smp,
    input  logic              clk_rd,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] depth,
    input  logic [TICK_W-1:0] fine_dly,
    input  logic [TICK_W-1:0] hold_margin,
    input  logic [TICK_W-1:0] period,
    output logic [DATA_W-1:0] dout
);
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_addr;
    dly_cfg_t          cfg_smp;
    dly_cfg_t          cfg_app;

    // Free-running write address counter on the sampling clock.
    always_ff @(posedge clk_smp) begin
        if (!rst_n) wr_ptr <= '0;
        else        wr_ptr <= wr_ptr + 1'b1;
    end

    sdl_cfg_capture #(.TICK_W(TICK_W)) u_cap (
        .clk      (clk_smp),
        .rst_n    (rst_n),
        .depth_in (depth),
        .fine     (fine_dly),
        .margin   (hold_margin),
        .period   (period),
        .cfg_q    (cfg_smp)
    );

    sdl_cfg_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk_rd),
        .rst_n   (rst_n),
        .cfg_in  (cfg_smp),
        .cfg_out (cfg_app)
    );

    sdl_addr_retime u_rt (
        .clk_smp  (clk_smp),
        .rst_n    (rst_n),
        .wr_ptr   (wr_ptr),
        .edge_sel (cfg_app.edge_sel),
        .depth    (cfg_app.depth),
        .rd_addr  (rd_addr)
    );

    sdl_dpram #(.DATA_W(DATA_W)) u_ram (
        .clk_wr (clk_smp),
        .we     (rst_n),
        .waddr  (wr_ptr),
        .wdata  (din),
        .clk_rd (clk_rd),
        .rst_n  (rst_n),
        .raddr  (rd_addr),
        .rdata  (dout)
    );

    // R7
    steady_rd_addr_step_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && cfg_app == $past(cfg_app))
        |-> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));
endmodule

// File: tb/tb_sample_delay_line.sv
// Bench: the read clock lags the sampling clock by 3 ns (period 8 ns). A
// behavioural history of inputs, indexed by sampling edge, predicts dout.
module tb_sample_delay_line;
    localparam int DW = 14;
    localparam int TW = 8;
    localparam int HIST = 8192;

    logic          clk_smp = 1'b0;
    logic          clk_rd  = 1'b0;
    logic          rst_n   = 1'b0;
    logic [DW-1:0] din     = '0;
    logic [7:0]    depth   = 8'd5;
    logic [TW-1:0] fine    = 8'd1;
    logic [TW-1:0] margin  = 8'd5;
    logic [TW-1:0] period  = 8'd8;
    logic [DW-1:0] dout;

    int    n_chk = 0;
    int    n_err = 0;
    string tag   = "R8";
    bit    done  = 1'b0;
    bit    told  = 1'b0;

    int din_h [HIST];
    int dep_h [HIST];
    int edg_h [HIST];
    int ks = 0;
    int kr = 0;
    int edge_m = 0;

    sample_delay_line #(.DATA_W(DW), .TICK_W(TW)) dut (
        .clk_smp(clk_smp), .clk_rd(clk_rd), .rst_n(rst_n), .din(din),
        .depth(depth), .fine_dly(fine), .hold_margin(margin),
        .period(period), .dout(dout)
    );

    initial forever #4 clk_smp = ~clk_smp;
    initial begin #3; forever #4 clk_rd = ~clk_rd; end

    task automatic check(bit ok, string t, int got, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s got=%0d exp=%0d", t, got, exp);
        end
    endtask

    task automatic summary();
        if (!told) begin
            told = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
    endtask

    // Record inputs seen at each sampling edge; model the edge choice (R3, R5).
    always @(posedge clk_smp) begin
        if (!rst_n) begin
            ks = 0;
            edge_m = 0;
        end else begin
            if (ks < HIST) begin
                din_h[ks] = int'(din);
                dep_h[ks] = (depth < 8'd2) ? 2 : int'(depth);
                if (fine < period) edge_m = (fine >= margin) ? 1 : 0;
                edg_h[ks] = edge_m;
            end
            ks++;
        end
    end

    // Compare dout 2 ns after every read edge against the history (R1, R2, R4, R7, R9).
    always @(posedge clk_rd) begin
        bit r;
        int k, d, e, src;
        r = rst_n;
        if (!r) begin
            kr = 0;
            #2;
            check(dout == '0, "R8 reset output", int'(dout), 0);
        end else begin
            k = kr;
            kr++;
            #2;
            if (k >= 2 && k - 2 < HIST) begin
                d = dep_h[k-2];
                e = edg_h[k-2];
            end else begin
                d = 2;
                e = 0;
            end
            src = k - d - e;
            if (src >= 0 && k < HIST)
                check(int'(dout) == din_h[src], tag, int'(dout), din_h[src]);
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_smp);
            din = DW'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_smp);
        rst_n = 1'b1;
        tag = "R1 wrap, depth 5 rise";   run(300);
        tag = "R2 depth 12 rise";        depth = 8'd12; run(100);
        tag = "R9 depth 12->11";         depth = 8'd11; run(50);
        tag = "R9 depth 11->12";         depth = 8'd12; run(50);
        tag = "R7 joint depth+edge step"; depth = 8'd3; fine = 8'd6; run(60);
        tag = "R4 fall, early read edge"; depth = 8'd10; fine = 8'd2; margin = 8'd2; run(80);
        tag = "R5 fine above period";    fine = 8'd20; run(60);
        tag = "R5 fine equal period";    fine = 8'd8; run(30);
        tag = "R3 back to rise";         fine = 8'd1; run(60);
        tag = "R6 depth 0 clamps";       depth = 8'd0; run(40);
        tag = "R6 depth 1 clamps";       depth = 8'd1; run(40);
        tag = "R6 depth 255";            depth = 8'd255; run(600);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule